// File: doc/BRIEF.md
# Selected-Device SRAM Read Sequencer

This block is the device-side controller that carries out an indirect SRAM read on behalf of one member of a cascaded table of lookup coprocessors (up to 31 members). It watches a shared command bus qualified by a valid strobe. A read reaches it as two consecutive command phases. The wide shared data bus carries the address word in both phases. A two-bit selector field in that word marks the access as an SRAM access, and a five-bit field names the target device.

When the named device matches the strapped identity input, the block runs a fixed ten-cycle schedule. Cycles 2 and 3 leave the data bus to turn around. Cycles 4 to 7 drive the data bus, and cycle 7 fires the SRAM read strobe. From cycle 8 the block claims the shared ownership line by pulling it low. It drives the acknowledge high for cycle 9 and low for cycle 10, then releases every shared line. All shared outputs are given as value/enable pairs. The ownership line is only ever driven low, so it has an enable alone.

Top module: `sram_rd_seq`

## Requirements
- R1: While synchronous reset is applied, and in the cycle after it, dq_oe, sram_rd, acl_drive, ack and ack_oe are all 0.
- R2: A read is accepted only after two consecutive cycles in which cmd_valid=1, cmd[1:0]=2'b01 (read opcode) and dq_in[20:19]=2'b10. Phase A alone, followed by a cycle without a valid read, starts nothing.
- R3: The device takes part only when dq_in[25:21] in phase A equals dev_id. On a mismatch every enable and strobe stays 0 for the whole would-be schedule.
- R4: Counting phase A as cycle 1 and phase B as cycle 1B, dq_oe is 0 in cycles 2 and 3 and 1 in cycles 4 through 7 only.
- R5: sram_rd is 1 in cycle 7 only. In cycles 4 to 7, sram_addr and dq_out[20:0] both equal {cmd[8:7] from phase A, dq_in[18:0] from phase B}, and dq_out bits above 20 are 0.
- R6: acl_drive (ownership line pulled low) is 1 in cycles 8, 9 and 10 and 0 from cycle 11.
- R7: ack is 1 in cycle 9 only. ack_oe is 1 in cycles 9 and 10 only.
- R8: Command phases that arrive during cycles 2 to 10 are ignored. A new read may start with phase A in cycle 11.
- R9: A synchronous reset in the middle of a sequence returns the block to idle, with all enables 0 from the next cycle, and nothing resumes after reset is released.
- R10: A command whose selector dq_in[20:19] is not 2'b10, or whose opcode is not the read code, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command bus qualifier |
| cmd | input | 9 | Command bus: opcode [1:0], upper SRAM address [8:7] |
| dq_in | input | 68 | Shared data bus as seen by this device |
| dev_id | input | 5 | Strapped device identity |
| dq_out | output | 68 | Value driven onto the data bus |
| dq_oe | output | 1 | Data bus drive enable |
| sram_addr | output | 21 | SRAM address captured from the command |
| sram_rd | output | 1 | SRAM read strobe |
| acl_drive | output | 1 | Pull the shared ownership line low |
| ack | output | 1 | Acknowledge value |
| ack_oe | output | 1 | Acknowledge drive enable |

## Verification
The schedule is checked cycle by cycle for a matching read with two different address words. The two phases carry different low address bits, so the test shows which phase the address is taken from. Mismatched identities, a wrong selector, a wrong opcode and a lone phase A must all leave every enable at 0, which shows that selection depends on all three fields and on both phases. A second read injected in mid-schedule must not restart or extend the first, while one issued in cycle 11 must run in full. A reset in mid-schedule must release all outputs at once.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;
   typedef logic [3:0] step_t;
   localparam step_t STEP_IDLE     = 4'd0;
   localparam step_t STEP_HAVE_A   = 4'd1;
   localparam step_t STEP_FIRST    = 4'd2;
   localparam step_t STEP_DQ_ON    = 4'd4;
   localparam step_t STEP_DQ_OFF   = 4'd7;
   localparam step_t STEP_STROBE   = 4'd7;
   localparam step_t STEP_CLAIM    = 4'd8;
   localparam step_t STEP_ACK_HI   = 4'd9;
   localparam step_t STEP_LAST     = 4'd10;
   localparam logic [1:0] SEL_SRAM = 2'b10;
endpackage

// File: rtl/sram_cmd_match.sv
module sram_cmd_match #(
   parameter int CMD_W    = 9,
   parameter int DQ_W     = 68,
   parameter int ID_W     = 5,
   parameter int ID_LSB   = 21,
   parameter int SEL_LSB  = 19,
   parameter int OPC_W    = 2,
   parameter logic [OPC_W-1:0] OPC_READ = 2'b01
) (
   input  logic             cmd_valid,
   input  logic [CMD_W-1:0] cmd,
   input  logic [DQ_W-1:0]  dq_in,
   input  logic [ID_W-1:0]  dev_id,
   output logic             is_read,
   output logic             id_hit
);
   import sram_seq_pkg::*;
   logic [1:0]      sel_f;
   logic [ID_W-1:0] id_f;

   always_comb begin
      sel_f   = dq_in[SEL_LSB +: 2];
      id_f    = dq_in[ID_LSB +: ID_W];
      is_read = cmd_valid && (cmd[OPC_W-1:0] == OPC_READ) && (sel_f == SEL_SRAM);
      id_hit  = (id_f == dev_id);
   end
endmodule

// File: rtl/sram_step_ctr.sv
module sram_step_ctr (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 is_read,
   input  logic                 id_hit,
   output sram_seq_pkg::step_t  step,
   output logic                 cap_a,
   output logic                 cap_b
);
   import sram_seq_pkg::*;
   step_t step_q, step_d;

   always_comb begin
      step_d = step_q;
      cap_a  = 1'b0;
      cap_b  = 1'b0;
      if (step_q == STEP_IDLE) begin
         if (is_read && id_hit) begin
            step_d = STEP_HAVE_A;
            cap_a  = 1'b1;
         end
      end else if (step_q == STEP_HAVE_A) begin
         if (is_read) begin
            step_d = STEP_FIRST;
            cap_b  = 1'b1;
         end else begin
            step_d = STEP_IDLE;
         end
      end else if (step_q == STEP_LAST) begin
         step_d = STEP_IDLE;
      end else begin
         step_d = step_q + 4'd1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) step_q <= STEP_IDLE;
      else     step_q <= step_d;
   end

   assign step = step_q;
endmodule

// File: rtl/sram_drive_stage.sv
module sram_drive_stage #(
   parameter int CMD_W  = 9,
   parameter int DQ_W   = 68,
   parameter int HI_LSB = 7,
   parameter int HI_W   = 2,
   parameter int LO_W   = 19,
   localparam int ADDR_W = HI_W + LO_W
) (
   input  logic                clk,
   input  logic                rst,
   input  sram_seq_pkg::step_t step,
   input  logic                cap_a,
   input  logic                cap_b,
   input  logic [CMD_W-1:0]    cmd,
   input  logic [DQ_W-1:0]     dq_in,
   output logic [ADDR_W-1:0]   sram_addr,
   output logic [DQ_W-1:0]     dq_out,
   output logic                dq_oe,
   output logic                sram_rd,
   output logic                acl_drive,
   output logic                ack,
   output logic                ack_oe
);
   import sram_seq_pkg::*;
   logic [HI_W-1:0] hi_q;
   logic [LO_W-1:0] lo_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         hi_q <= '0;
         lo_q <= '0;
      end else begin
         if (cap_a) hi_q <= cmd[HI_LSB +: HI_W];
         if (cap_b) lo_q <= dq_in[LO_W-1:0];
      end
   end

   assign sram_addr = {hi_q, lo_q};

   generate
      if (DQ_W > ADDR_W) begin : g_pad
         assign dq_out = {{(DQ_W-ADDR_W){1'b0}}, sram_addr};
      end else begin : g_exact
         assign dq_out = sram_addr[DQ_W-1:0];
      end
   endgenerate

   always_comb begin
      dq_oe     = (step >= STEP_DQ_ON) && (step <= STEP_DQ_OFF);
      sram_rd   = (step == STEP_STROBE);
      acl_drive = (step >= STEP_CLAIM) && (step <= STEP_LAST);
      ack       = (step == STEP_ACK_HI);
      ack_oe    = (step >= STEP_ACK_HI) && (step <= STEP_LAST);
   end
endmodule

// File: rtl/sram_rd_seq.sv
module sram_rd_seq #(
   parameter int CMD_W   = 9,
   parameter int DQ_W    = 68,
   parameter int ID_W    = 5,
   parameter int ID_LSB  = 21,
   parameter int SEL_LSB = 19,
   parameter int HI_LSB  = 7,
   parameter int HI_W    = 2,
   parameter int LO_W    = 19,
   localparam int ADDR_W = HI_W + LO_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmd_valid,
   input  logic [CMD_W-1:0]  cmd,
   input  logic [DQ_W-1:0]   dq_in,
   input  logic [ID_W-1:0]   dev_id,
   output logic [DQ_W-1:0]   dq_out,
   output logic              dq_oe,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_rd,
   output logic              acl_drive,
   output logic              ack,
   output logic              ack_oe
);
   import sram_seq_pkg::*;

   generate
      if (ID_LSB + ID_W > DQ_W) begin : g_bad_id
         $error("device id field exceeds data bus");
      end
      if (SEL_LSB + 2 > ID_LSB) begin : g_bad_sel
         $error("selector overlaps id field");
      end
      if (LO_W > SEL_LSB) begin : g_bad_lo
         $error("low address overlaps selector");
      end
      if (HI_LSB + HI_W > CMD_W) begin : g_bad_hi
         $error("upper address exceeds command bus");
      end
   endgenerate

   logic  is_read, id_hit, cap_a, cap_b;
   step_t step;

   sram_cmd_match #(
      .CMD_W(CMD_W), .DQ_W(DQ_W), .ID_W(ID_W),
      .ID_LSB(ID_LSB), .SEL_LSB(SEL_LSB)
   ) u_match (
      .cmd_valid(cmd_valid), .cmd(cmd), .dq_in(dq_in), .dev_id(dev_id),
      .is_read(is_read), .id_hit(id_hit)
   );

   sram_step_ctr u_ctr (
      .clk(clk), .rst(rst), .is_read(is_read), .id_hit(id_hit),
      .step(step), .cap_a(cap_a), .cap_b(cap_b)
   );

   sram_drive_stage #(
      .CMD_W(CMD_W), .DQ_W(DQ_W), .HI_LSB(HI_LSB), .HI_W(HI_W), .LO_W(LO_W)
   ) u_drive (
      .clk(clk), .rst(rst), .step(step), .cap_a(cap_a), .cap_b(cap_b),
      .cmd(cmd), .dq_in(dq_in), .sram_addr(sram_addr), .dq_out(dq_out),
      .dq_oe(dq_oe), .sram_rd(sram_rd), .acl_drive(acl_drive),
      .ack(ack), .ack_oe(ack_oe)
   );
endmodule

// File: rtl/sram_rd_seq_chk.sv
module sram_rd_seq_chk (
   input logic clk,
   input logic rst,
   input logic dq_oe,
   input logic sram_rd,
   input logic acl_drive,
   input logic ack,
   input logic ack_oe
);
   // R1
   reset_release_chk: assert property (@(posedge clk)
      rst |=> (!dq_oe && !sram_rd && !acl_drive && !ack && !ack_oe));

   // R4
   bus_line_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
      !(dq_oe && acl_drive));

   // R5
   strobe_in_drive_chk: assert property (@(posedge clk) disable iff (rst)
      sram_rd |-> (dq_oe && !acl_drive));

   // R6
   claim_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(acl_drive) |-> $past(sram_rd));

   // R7
   ack_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      ack |=> (!ack && ack_oe && acl_drive));

   // R7
   ack_under_claim_chk: assert property (@(posedge clk) disable iff (rst)
      ack_oe |-> acl_drive);
endmodule

bind sram_rd_seq sram_rd_seq_chk u_chk (
   .clk(clk), .rst(rst), .dq_oe(dq_oe), .sram_rd(sram_rd),
   .acl_drive(acl_drive), .ack(ack), .ack_oe(ack_oe)
);

// File: tb/sram_rd_seq_tb.sv
module sram_rd_seq_tb;
   localparam logic [4:0] MY_ID = 5'd13;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cmd_valid = 1'b0;
   logic [8:0]  cmd = '0;
   logic [67:0] dq_in = '0;
   logic [67:0] dq_out;
   logic        dq_oe, sram_rd, acl_drive, ack, ack_oe;
   logic [20:0] sram_addr;
   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   sram_rd_seq u_dut (
      .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd), .dq_in(dq_in),
      .dev_id(MY_ID), .dq_out(dq_out), .dq_oe(dq_oe), .sram_addr(sram_addr),
      .sram_rd(sram_rd), .acl_drive(acl_drive), .ack(ack), .ack_oe(ack_oe)
   );

   function automatic logic [67:0] word(input logic [4:0] id, input logic [1:0] sel,
                                        input logic [18:0] lo);
      word = '0;
      word[25:21] = id;
      word[20:19] = sel;
      word[18:0]  = lo;
   endfunction

   task automatic chk(input logic ok, input string tag, input logic [67:0] act,
                      input logic [67:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [4:0] outs();
      outs = {dq_oe, sram_rd, acl_drive, ack, ack_oe};
   endfunction

   function automatic logic [4:0] exp_outs(input int k);
      exp_outs = {(k >= 4 && k <= 7), (k == 7), (k >= 8 && k <= 10),
                  (k == 9), (k >= 9 && k <= 10)};
   endfunction

   task automatic idle_bus();
      cmd_valid = 1'b0;
      cmd = '0;
      dq_in = '0;
   endtask

   // drive phase A then B, return at the negedge that starts cycle 2
   task automatic issue(input logic [4:0] id, input logic [1:0] sel,
                        input logic [1:0] opc, input logic [1:0] hi,
                        input logic [18:0] lo_a, input logic [18:0] lo_b,
                        input logic second);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd = {hi, 5'b0, opc};
      dq_in = word(id, sel, lo_a);
      @(negedge clk);
      cmd_valid = second;
      cmd = {2'b00, 5'b0, opc};
      dq_in = word(id, sel, lo_b);
      @(negedge clk);
      idle_bus();
   endtask

   task automatic t_reset();
      chk(outs() == 5'b0, "R1 reset outputs", 68'(outs()), 68'd0);
   endtask

   task automatic t_schedule(input logic [1:0] hi, input logic [18:0] lo_a,
                             input logic [18:0] lo_b);
      logic [20:0] ea;
      ea = {hi, lo_b};
      issue(MY_ID, 2'b10, 2'b01, hi, lo_a, lo_b, 1'b1);
      for (int k = 2; k <= 12; k++) begin
         chk(outs() == exp_outs(k), "R4/R5/R6/R7 schedule", 68'(outs()), 68'(exp_outs(k)));
         if (k >= 4 && k <= 7) begin
            chk(sram_addr == ea, "R5 sram_addr", 68'(sram_addr), 68'(ea));
            chk(dq_out == 68'(ea), "R5 dq_out", dq_out, 68'(ea));
         end
         @(negedge clk);
      end
   endtask

   task automatic t_ignored(input logic [4:0] id, input logic [1:0] sel,
                            input logic [1:0] opc, input logic second, input string tag);
      issue(id, sel, opc, 2'b11, 19'h1234, 19'h5678, second);
      for (int k = 2; k <= 11; k++) begin
         chk(outs() == 5'b0, tag, 68'(outs()), 68'd0);
         @(negedge clk);
      end
   endtask

   task automatic t_busy_then_next();
      issue(MY_ID, 2'b10, 2'b01, 2'b01, 19'h0, 19'h00AA, 1'b1);
      // now cycle 2; inject a read in cycles 5 and 6
      for (int k = 2; k <= 10; k++) begin
         chk(outs() == exp_outs(k), "R8 busy schedule", 68'(outs()), 68'(exp_outs(k)));
         if (k == 5 || k == 6) begin
            cmd_valid = 1'b1;
            cmd = {2'b10, 5'b0, 2'b01};
            dq_in = word(MY_ID, 2'b10, 19'h7FFFF);
         end else begin
            idle_bus();
         end
         @(negedge clk);
      end
      // cycle 11: check injected read did not restart
      chk(outs() == 5'b0, "R8 no restart", 68'(outs()), 68'd0);
      chk(sram_addr == {2'b01, 19'h00AA}, "R8 addr kept", 68'(sram_addr),
          68'({2'b01, 19'h00AA}));
      // phase A in cycle 11 accepted
      cmd_valid = 1'b1;
      cmd = {2'b11, 5'b0, 2'b01};
      dq_in = word(MY_ID, 2'b10, 19'h1);
      @(negedge clk);
      dq_in = word(MY_ID, 2'b10, 19'h00F0);
      cmd = {2'b00, 5'b0, 2'b01};
      @(negedge clk);
      idle_bus();
      for (int k = 2; k <= 11; k++) begin
         chk(outs() == exp_outs(k), "R8 back-to-back", 68'(outs()), 68'(exp_outs(k)));
         @(negedge clk);
      end
   endtask

   task automatic t_mid_reset();
      issue(MY_ID, 2'b10, 2'b01, 2'b10, 19'h0, 19'h3, 1'b1);
      @(negedge clk); @(negedge clk); @(negedge clk);   // cycle 5
      chk(dq_oe == 1'b1, "R9 pre-reset drive", 68'(dq_oe), 68'd1);
      rst = 1'b1;
      @(negedge clk);
      chk(outs() == 5'b0, "R9 reset mid-sequence", 68'(outs()), 68'd0);
      rst = 1'b0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         chk(outs() == 5'b0, "R9 no resume", 68'(outs()), 68'd0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_schedule(2'b10, 19'h11111, 19'h2ABCD);
      t_schedule(2'b01, 19'h7FFFF, 19'h00001);
      t_ignored(5'd12, 2'b10, 2'b01, 1'b1, "R3 id mismatch");
      t_ignored(5'd31, 2'b10, 2'b01, 1'b1, "R3 id mismatch high");
      t_ignored(MY_ID, 2'b01, 2'b01, 1'b1, "R10 selector");
      t_ignored(MY_ID, 2'b10, 2'b10, 1'b1, "R10 opcode");
      t_ignored(MY_ID, 2'b10, 2'b01, 1'b0, "R2 lone phase A");
      t_busy_then_next();
      t_mid_reset();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule